// File: doc/BRIEF.md
# Progressive PAL Sync Timing Generator

This block drives the two logic-level pins that feed a resistor-divider composite video stage. The divider turns the pin pair into three analog levels: sync tip, black and white. The block runs from a 16 MHz clock and produces one progressive frame of `LINES` lines. Each line is `CLKS_PER_LINE` clocks long. Within the frame it places the vertical sync lines, the horizontal sync and back porch of each picture line, and a rectangular active-picture window.

A vertical sync line is handled as two half-lines. Each half-line carries either a long pulse (mostly low) or a short pulse (mostly high). A small line-indexed table decides which pulse each half-line gets. Picture lines start with a horizontal sync interval, then a back porch at black level. After the porch the window may open. The window starts after a blank top border and is `ACTIVE_LINES` lines tall and `ACTIVE_CLKS` clocks wide.

While the window is open, the block shows `pixel_i` on the video pin. It also gives a pixel source its position inside the window, plus strobes for frame start and line start. The top module uses an active-low asynchronous reset.

Top module: `pal_sync_gen`

## Requirements
- R1: While reset is low, and right after reset is asserted, the counters are at line 1, clock 0. In that state `sync_o`=0, `video_o`=0, and both `sof_o` and `sol_o` are 1.
- R2: `hcnt_o` counts 0 to `CLKS_PER_LINE`-1 (default 1024) and then wraps to 0. At each wrap `line_o` steps by one. After line `LINES` (default 312) it returns to line 1.
- R3: On lines 1 and 2, each half-line holds a long pulse. The first half-line covers clocks 0..511 and the second covers 512..1023. At each half-line offset, `sync_o` is 0 for offsets 0..479 and 1 for offsets 480..511.
- R4: Line 3 has a long pulse in its first half-line and a short pulse in its second. So `sync_o` is 0 on clocks 512..543 and 1 on clocks 544..1023.
- R5: Lines 4, 5 and the last three lines of the frame carry short pulses in both half-lines. At each half-line offset, `sync_o` is 0 for offsets 0..31 and 1 for offsets 32..511.
- R6: On picture lines (lines 6 to `LINES`-3), clocks 0..74 are at the sync level: `sync_o`=0 and `video_o`=0.
- R7: On picture lines, clocks 75..100 form the back porch at black level. `sync_o` is 1 and `video_o` is 0 whatever `pixel_i` is, and `active_o` is 0.
- R8: `active_o` is 1 only on lines 6+`TOP_BORDER` through 6+`TOP_BORDER`+`ACTIVE_LINES`-1, and only at clocks 101 through 100+`ACTIVE_CLKS`. Inside that window `video_o` follows `pixel_i` in the same cycle. Outside it on a picture line, the outputs sit at black (`sync_o`=1, `video_o`=0).
- R9: While `active_o` is 1, `pix_x_o` is `hcnt_o`-101 and `pix_y_o` is `line_o`-(6+`TOP_BORDER`). While `active_o` is 0, both are 0.
- R10: `sol_o` is 1 exactly in the clock where `hcnt_o`=0. `sof_o` is 1 exactly in the clock where `hcnt_o`=0 and `line_o`=1.
- R11: The pin encoding is sync level = (`sync_o`=0, `video_o`=0), black = (1,0) and white = (1,1). `video_o` is never 1 while `sync_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pixel_i | input | 1 | Pixel value from the pixel source, used inside the window |
| sync_o | output | 1 | Sync pin; 0 selects the sync level |
| video_o | output | 1 | Video pin; 1 selects white when sync_o is 1 |
| active_o | output | 1 | Active-picture window flag |
| sof_o | output | 1 | Start-of-frame strobe |
| sol_o | output | 1 | Start-of-line strobe |
| line_o | output | L_W | Current line, 1-based |
| hcnt_o | output | H_W | Clock index within the line |
| pix_x_o | output | PX_W | Clock index within the window |
| pix_y_o | output | PY_W | Line index within the window |

## Verification
Two things coincide at the frame boundary. One clock closes the last short-pulse line, and the next clock opens line 1 with its long pulse. In that same clock both the frame strobe and the line strobe must rise. The bench reaches that wrap by running the counters to the last clock of the last line. It then checks, in the one following cycle, that both strobes are high, the line is 1, and the sync pin has dropped for the long pulse. A second overlap comes from sampling the first clock of the window edge while `pixel_i` changes in that same cycle. This checks that the video pin follows the pixel without a cycle of delay and opens no earlier than the porch end.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

  typedef enum logic [1:0] {
    PULSE_NONE  = 2'd0,
    PULSE_LONG  = 2'd1,
    PULSE_SHORT = 2'd2
  } pulse_e;

  // first picture line; lines before it carry vertical sync
  localparam int unsigned PIC_FIRST_LINE = 6;
  // short-pulse lines at the frame tail
  localparam int unsigned TAIL_SYNC_LINES = 3;

endpackage

// File: rtl/pal_line_timer.sv
module pal_line_timer #(
  parameter int unsigned CLKS_PER_LINE = 1024,
  parameter int unsigned LINES         = 312,
  parameter int unsigned H_W           = 10,
  parameter int unsigned L_W           = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [H_W-1:0] hcnt_o,
  output logic [L_W-1:0] line_o,
  output logic           sol_o,
  output logic           sof_o
);

  localparam logic [H_W-1:0] H_LAST  = H_W'(CLKS_PER_LINE - 1);
  localparam logic [L_W-1:0] L_FIRST = L_W'(1);
  localparam logic [L_W-1:0] L_LAST  = L_W'(LINES);

  logic [H_W-1:0] hcnt_q;
  logic [L_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      line_q <= L_FIRST;
    end else if (hcnt_q == H_LAST) begin
      hcnt_q <= '0;
      line_q <= (line_q == L_LAST) ? L_FIRST : line_q + L_W'(1);
    end else begin
      hcnt_q <= hcnt_q + H_W'(1);
    end
  end

  assign hcnt_o = hcnt_q;
  assign line_o = line_q;
  assign sol_o  = (hcnt_q == '0);
  assign sof_o  = (hcnt_q == '0) && (line_q == L_FIRST);

endmodule

// File: rtl/pal_vsync_table.sv
module pal_vsync_table
  import pal_sync_pkg::*;
#(
  parameter int unsigned LINES = 312,
  parameter int unsigned L_W   = 9
) (
  input  logic [L_W-1:0] line_i,
  input  logic           second_half_i,
  output pulse_e         pulse_o,
  output logic           picture_o
);

  localparam logic [L_W-1:0] L_LONG_END  = L_W'(2);
  localparam logic [L_W-1:0] L_MIXED     = L_W'(3);
  localparam logic [L_W-1:0] L_HEAD_END  = L_W'(PIC_FIRST_LINE - 1);
  localparam logic [L_W-1:0] L_TAIL_BEG  = L_W'(LINES - TAIL_SYNC_LINES + 1);

  always_comb begin
    picture_o = 1'b0;
    if (line_i <= L_LONG_END) begin
      pulse_o = PULSE_LONG;
    end else if (line_i == L_MIXED) begin
      pulse_o = second_half_i ? PULSE_SHORT : PULSE_LONG;
    end else if (line_i <= L_HEAD_END || line_i >= L_TAIL_BEG) begin
      pulse_o = PULSE_SHORT;
    end else begin
      pulse_o   = PULSE_NONE;
      picture_o = 1'b1;
    end
  end

endmodule

// File: rtl/pal_active_window.sv
module pal_active_window #(
  parameter int unsigned L_W          = 9,
  parameter int unsigned H_W          = 10,
  parameter int unsigned PX_W         = 10,
  parameter int unsigned PY_W         = 8,
  parameter int unsigned L_ACT0       = 38,
  parameter int unsigned ACTIVE_LINES = 256,
  parameter int unsigned H_ACT0       = 101,
  parameter int unsigned ACTIVE_CLKS  = 800
) (
  input  logic [L_W-1:0]  line_i,
  input  logic [H_W-1:0]  hcnt_i,
  input  logic            picture_i,
  output logic            active_o,
  output logic [PX_W-1:0] pix_x_o,
  output logic [PY_W-1:0] pix_y_o
);

  localparam logic [L_W-1:0] V_FIRST = L_W'(L_ACT0);
  localparam logic [L_W-1:0] V_LAST  = L_W'(L_ACT0 + ACTIVE_LINES - 1);
  localparam logic [H_W-1:0] H_FIRST = H_W'(H_ACT0);
  localparam logic [H_W-1:0] H_LAST  = H_W'(H_ACT0 + ACTIVE_CLKS - 1);

  logic           in_v, in_h;
  logic [H_W-1:0] x_off;
  logic [L_W-1:0] y_off;

  assign in_v     = (line_i >= V_FIRST) && (line_i <= V_LAST);
  assign in_h     = (hcnt_i >= H_FIRST) && (hcnt_i <= H_LAST);
  assign active_o = picture_i && in_v && in_h;
  assign x_off    = hcnt_i - H_FIRST;
  assign y_off    = line_i - V_FIRST;
  assign pix_x_o  = active_o ? PX_W'(x_off) : '0;
  assign pix_y_o  = active_o ? PY_W'(y_off) : '0;

endmodule

// File: rtl/pal_level_mux.sv
module pal_level_mux
  import pal_sync_pkg::*;
#(
  parameter int unsigned CLKS_PER_LINE = 1024,
  parameter int unsigned H_W           = 10,
  parameter int unsigned HSYNC_CLKS    = 75,
  parameter int unsigned LONG_LOW      = 480,
  parameter int unsigned SHORT_LOW     = 32
) (
  input  logic [H_W-1:0] hcnt_i,
  input  logic           second_half_i,
  input  pulse_e         pulse_i,
  input  logic           active_i,
  input  logic           pixel_i,
  output logic           sync_o,
  output logic           video_o
);

  localparam logic [H_W-1:0] HALF    = H_W'(CLKS_PER_LINE / 2);
  localparam logic [H_W-1:0] HS_END  = H_W'(HSYNC_CLKS);
  localparam logic [H_W-1:0] LNG_END = H_W'(LONG_LOW);
  localparam logic [H_W-1:0] SHT_END = H_W'(SHORT_LOW);

  logic [H_W-1:0] offset;

  assign offset = second_half_i ? hcnt_i - HALF : hcnt_i;

  always_comb begin
    unique case (pulse_i)
      PULSE_LONG:  sync_o = (offset >= LNG_END);
      PULSE_SHORT: sync_o = (offset >= SHT_END);
      default:     sync_o = (hcnt_i >= HS_END);
    endcase
  end

  // window never overlaps sync or porch, so white only rides on black
  assign video_o = active_i && pixel_i;

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_sync_pkg::*;
#(
  parameter int unsigned CLKS_PER_LINE = 1024,
  parameter int unsigned LINES         = 312,
  parameter int unsigned HSYNC_CLKS    = 75,
  parameter int unsigned PORCH_CLKS    = 26,
  parameter int unsigned LONG_LOW      = 480,
  parameter int unsigned SHORT_LOW     = 32,
  parameter int unsigned TOP_BORDER    = 32,
  parameter int unsigned ACTIVE_LINES  = 256,
  parameter int unsigned ACTIVE_CLKS   = 800,
  parameter int unsigned L_W           = $clog2(LINES + 1),
  parameter int unsigned H_W           = $clog2(CLKS_PER_LINE),
  parameter int unsigned PX_W          = $clog2(ACTIVE_CLKS),
  parameter int unsigned PY_W          = $clog2(ACTIVE_LINES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pixel_i,
  output logic            sync_o,
  output logic            video_o,
  output logic            active_o,
  output logic            sof_o,
  output logic            sol_o,
  output logic [L_W-1:0]  line_o,
  output logic [H_W-1:0]  hcnt_o,
  output logic [PX_W-1:0] pix_x_o,
  output logic [PY_W-1:0] pix_y_o
);

  localparam int unsigned H_ACT0 = HSYNC_CLKS + PORCH_CLKS;
  localparam int unsigned L_ACT0 = PIC_FIRST_LINE + TOP_BORDER;
  localparam logic [H_W-1:0] HALF = H_W'(CLKS_PER_LINE / 2);

  logic [H_W-1:0] hcnt;
  logic [L_W-1:0] line;
  logic           second_half;
  logic           picture;
  logic           active;
  pulse_e         pulse;

  pal_line_timer #(
    .CLKS_PER_LINE(CLKS_PER_LINE), .LINES(LINES), .H_W(H_W), .L_W(L_W)
  ) u_timer (
    .clk_i, .rst_ni, .hcnt_o(hcnt), .line_o(line), .sol_o, .sof_o
  );

  assign second_half = (hcnt >= HALF);

  pal_vsync_table #(.LINES(LINES), .L_W(L_W)) u_vtab (
    .line_i(line), .second_half_i(second_half), .pulse_o(pulse), .picture_o(picture)
  );

  pal_active_window #(
    .L_W(L_W), .H_W(H_W), .PX_W(PX_W), .PY_W(PY_W),
    .L_ACT0(L_ACT0), .ACTIVE_LINES(ACTIVE_LINES),
    .H_ACT0(H_ACT0), .ACTIVE_CLKS(ACTIVE_CLKS)
  ) u_win (
    .line_i(line), .hcnt_i(hcnt), .picture_i(picture),
    .active_o(active), .pix_x_o, .pix_y_o
  );

  pal_level_mux #(
    .CLKS_PER_LINE(CLKS_PER_LINE), .H_W(H_W), .HSYNC_CLKS(HSYNC_CLKS),
    .LONG_LOW(LONG_LOW), .SHORT_LOW(SHORT_LOW)
  ) u_mux (
    .hcnt_i(hcnt), .second_half_i(second_half), .pulse_i(pulse),
    .active_i(active), .pixel_i, .sync_o, .video_o
  );

  assign active_o = active;
  assign line_o   = line;
  assign hcnt_o   = hcnt;

endmodule

// File: rtl/pal_sync_gen_chk.sv
module pal_sync_gen_chk #(
  parameter int unsigned CLKS_PER_LINE = 1024,
  parameter int unsigned LINES         = 312,
  parameter int unsigned H_ACT0        = 101,
  parameter int unsigned L_W           = 9,
  parameter int unsigned H_W           = 10,
  parameter int unsigned PX_W          = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sync_o,
  input logic            video_o,
  input logic            active_o,
  input logic            sof_o,
  input logic            sol_o,
  input logic [L_W-1:0]  line_o,
  input logic [H_W-1:0]  hcnt_o,
  input logic [PX_W-1:0] pix_x_o
);

  localparam logic [H_W-1:0] H_LAST = H_W'(CLKS_PER_LINE - 1);
  localparam logic [L_W-1:0] L_LAST = L_W'(LINES);
  localparam logic [H_W-1:0] H_A0   = H_W'(H_ACT0);

  logic [H_W-1:0] x_exp;
  assign x_exp = hcnt_o - H_A0;

  assert_no_white_in_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o |-> !video_o);

  assert_frame_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_o == H_LAST && line_o == L_LAST) |=> (line_o == L_W'(1) && hcnt_o == '0 && sof_o));

  assert_clock_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_o != H_LAST) |=> (hcnt_o == $past(hcnt_o) + H_W'(1) && $stable(line_o)));

  assert_strobe_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |=> !sol_o && !sof_o);

  assert_sof_within_sol_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> sol_o);

  assert_window_black_base_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> sync_o);

  assert_pix_x_track_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> pix_x_o == PX_W'(x_exp));

endmodule

bind pal_sync_gen pal_sync_gen_chk #(
  .CLKS_PER_LINE(CLKS_PER_LINE), .LINES(LINES), .H_ACT0(HSYNC_CLKS + PORCH_CLKS),
  .L_W(L_W), .H_W(H_W), .PX_W(PX_W)
) u_chk (
  .clk_i, .rst_ni, .sync_o, .video_o, .active_o, .sof_o, .sol_o,
  .line_o, .hcnt_o, .pix_x_o
);

// File: tb/tb_pal_sync_gen.sv
`timescale 1ns/1ps
module tb_pal_sync_gen;

  // shortened frame keeps the run bounded; horizontal timing stays exact
  localparam int LINES  = 40;
  localparam int TOP    = 4;
  localparam int ALINES = 16;
  localparam int ACLKS  = 800;
  localparam int CLKS   = 1024;
  localparam int L_W    = $clog2(LINES + 1);
  localparam int H_W    = $clog2(CLKS);
  localparam int PX_W   = $clog2(ACLKS);
  localparam int PY_W   = $clog2(ALINES);
  localparam int LA0    = 6 + TOP;
  localparam int LA1    = LA0 + ALINES - 1;
  localparam int HA0    = 101;
  localparam int HA1    = HA0 + ACLKS - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pixel_i = 1'b0;
  logic sync_o, video_o, active_o, sof_o, sol_o;
  logic [L_W-1:0]  line_o;
  logic [H_W-1:0]  hcnt_o;
  logic [PX_W-1:0] pix_x_o;
  logic [PY_W-1:0] pix_y_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pal_sync_gen #(
    .LINES(LINES), .TOP_BORDER(TOP), .ACTIVE_LINES(ALINES), .ACTIVE_CLKS(ACLKS)
  ) dut (
    .clk_i(clk), .rst_ni, .pixel_i, .sync_o, .video_o, .active_o,
    .sof_o, .sol_o, .line_o, .hcnt_o, .pix_x_o, .pix_y_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic goto(int l, int h);
    while (!(int'(line_o) == l && int'(hcnt_o) == h)) @(negedge clk);
  endtask

  task automatic lvl(string req, int l, int h, int s, int v);
    goto(l, h);
    chk({req, " sync"}, int'(sync_o), s);
    chk({req, " video"}, int'(video_o), v);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 line", int'(line_o), 1);
    chk("R1 hcnt", int'(hcnt_o), 0);
    chk("R1 sync", int'(sync_o), 0);
    chk("R1 video", int'(video_o), 0);
    chk("R1 sof", int'(sof_o), 1);
    chk("R1 sol", int'(sol_o), 1);
    rst_ni = 1'b1;
  endtask

  task automatic t_long_lines();
    pixel_i = 1'b1;
    goto(1, 1);
    chk("R10 sof after one clock", int'(sof_o), 0);
    chk("R10 sol after one clock", int'(sol_o), 0);
    lvl("R3 l1 479", 1, 479, 0, 0);
    lvl("R3 l1 480", 1, 480, 1, 0);
    lvl("R3 l1 511", 1, 511, 1, 0);
    lvl("R3 l1 512", 1, 512, 0, 0);
    lvl("R3 l1 991", 1, 991, 0, 0);
    lvl("R3 l1 992", 1, 992, 1, 0);
    goto(2, 0);
    chk("R10 sol line2", int'(sol_o), 1);
    chk("R10 sof line2", int'(sof_o), 0);
    lvl("R3 l2 480", 2, 480, 1, 0);
  endtask

  task automatic t_mixed_line();
    lvl("R4 l3 479", 3, 479, 0, 0);
    lvl("R4 l3 480", 3, 480, 1, 0);
    lvl("R4 l3 512", 3, 512, 0, 0);
    lvl("R4 l3 543", 3, 543, 0, 0);
    lvl("R4 l3 544", 3, 544, 1, 0);
  endtask

  task automatic t_short_head();
    lvl("R5 l4 31", 4, 31, 0, 0);
    lvl("R5 l4 32", 4, 32, 1, 0);
    lvl("R5 l4 543", 4, 543, 0, 0);
    lvl("R5 l4 544", 4, 544, 1, 0);
    lvl("R5 l5 480", 5, 480, 1, 0);
  endtask

  task automatic t_picture_line();
    lvl("R6 hsync start", 6, 0, 0, 0);
    lvl("R6 hsync end", 6, 74, 0, 0);
    lvl("R7 porch start", 6, 75, 1, 0);
    lvl("R7 porch end", 6, 100, 1, 0);
    chk("R7 porch not active", int'(active_o), 0);
    goto(6, HA0);
    chk("R8 border line inactive", int'(active_o), 0);
    chk("R8 border line black", int'(video_o), 0);
    chk("R9 pix_x zero outside", int'(pix_x_o), 0);
  endtask

  task automatic t_window();
    goto(LA0, HA0 - 1);
    chk("R8 before window", int'(active_o), 0);
    goto(LA0, HA0);
    chk("R8 window opens", int'(active_o), 1);
    chk("R8 white follows pixel", int'(video_o), 1);
    chk("R9 pix_x first", int'(pix_x_o), 0);
    chk("R9 pix_y first", int'(pix_y_o), 0);
    pixel_i = 1'b0;
    #0.5;
    chk("R8 black follows pixel", int'(video_o), 0);
    chk("R11 sync high in window", int'(sync_o), 1);
    pixel_i = 1'b1;
    goto(LA0, 500);
    chk("R9 pix_x mid", int'(pix_x_o), 500 - HA0);
    goto(LA0, HA1);
    chk("R8 last clock active", int'(active_o), 1);
    chk("R9 pix_x last", int'(pix_x_o), ACLKS - 1);
    goto(LA0, HA1 + 1);
    chk("R8 window closes", int'(active_o), 0);
    chk("R8 right border black", int'(video_o), 0);
    chk("R8 right border sync", int'(sync_o), 1);
    goto(LA1, HA0);
    chk("R8 last line active", int'(active_o), 1);
    chk("R9 pix_y last", int'(pix_y_o), ALINES - 1);
    goto(LA1 + 1, HA0);
    chk("R8 below window", int'(active_o), 0);
    chk("R9 pix_y zero outside", int'(pix_y_o), 0);
  endtask

  task automatic t_tail_and_wrap();
    lvl("R5 tail first 31", LINES - 2, 31, 0, 0);
    lvl("R5 tail first 32", LINES - 2, 32, 1, 0);
    lvl("R5 tail last 543", LINES, 543, 0, 0);
    lvl("R5 tail last 544", LINES, 544, 1, 0);
    goto(LINES, CLKS - 1);
    chk("R10 no sof at line end", int'(sof_o), 0);
    @(negedge clk);
    chk("R2 wrap line", int'(line_o), 1);
    chk("R2 wrap hcnt", int'(hcnt_o), 0);
    chk("R10 sof at wrap", int'(sof_o), 1);
    chk("R10 sol at wrap", int'(sol_o), 1);
    chk("R3 long pulse after wrap", int'(sync_o), 0);
  endtask

  task automatic t_midframe_reset();
    goto(LA0, 200);
    rst_ni = 1'b0;
    #0.5;
    chk("R1 async line", int'(line_o), 1);
    chk("R1 async hcnt", int'(hcnt_o), 0);
    chk("R1 async sof", int'(sof_o), 1);
    chk("R1 async video", int'(video_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    goto(2, 0);
    chk("R2 line length after reset", int'(line_o), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_long_lines();
    t_mixed_line();
    t_short_head();
    t_picture_line();
    t_window();
    t_tail_and_wrap();
    t_midframe_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule